// File: doc/BRIEF.md
# Multifunction 32-bit ALU

A purely combinational arithmetic and logic unit for a small single-cycle load/store processor. It joins four datapaths: a barrel shifter, an adder/subtractor, a signed less-than comparator built on that adder, and a four-function bitwise unit. All four see the same two operands, `opnd_a` and `opnd_b`. An 8-bit control word picks which result reaches `result`. The operation is set by small independent fields rather than one flat opcode: operation class, add/subtract, shift kind, shift amount source and bitwise function.

The adder always runs, whatever class is chosen. Its sum drives the zero flag, so a subtract-and-test-for-equal branch can use the ALU in any cycle. A dedicated `load_upper` input turns the shifter into the load-upper-immediate path. There is no clock, no state and no handshake. Results settle combinationally from the inputs, and the block never applies back-pressure. The surrounding single-cycle datapath registers whatever it needs at the end of the cycle.

Top module: `mfu_alu`

## Requirements
- R1: The control word is `ctrl[7:6]`=class, `ctrl[5]`=subtract, `ctrl[4:3]`=shift kind, `ctrl[2]`=variable amount, `ctrl[1:0]`=bitwise function. Class 00 routes the shifter to `result`, 01 the less-than bit, 10 the adder sum, and 11 the bitwise unit.
- R2: In class 10, `ctrl[5]`=0 gives `opnd_a + opnd_b` modulo 2^32, and `ctrl[5]`=1 gives `opnd_a - opnd_b` modulo 2^32.
- R3: `ovf` is 1 only in class 10, and only when the signed addition or subtraction result does not fit in 32 bits. In every other class it is 0.
- R4: `zero` is 1 exactly when the adder sum is all zeros, in every class. The adder subtracts when `ctrl[5]`=1 or the class is 01.
- R5: In class 01, `result` is 1 when `opnd_a < opnd_b` as signed numbers and 0 otherwise. This holds even when `opnd_a - opnd_b` overflows. Bits 31..1 are always 0.
- R6: In class 11, `ctrl[1:0]` 00 gives AND, 01 OR, 10 XOR and 11 NOR of the two operands.
- R7: In class 00, the shifted value is `opnd_b`. Kind 00 passes it unchanged, 01 shifts it left, 10 shifts it right logically, and 11 shifts it right arithmetically.
- R8: With `ctrl[2]`=0 the shift amount is `const_amt`. With `ctrl[2]`=1 it is `opnd_a[4:0]`.
- R9: An arithmetic right shift fills the vacated high bits with `opnd_b[31]`. A logical shift, left or right, fills with zeros.
- R10: With `load_upper`=1 in class 00, `result` is `{opnd_b[15:0], 16'h0000}`. Shift kind, `ctrl[2]`, `const_amt` and `opnd_b[31:16]` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; its low 5 bits supply the variable shift amount |
| opnd_b | input | 32 | Second operand; the value that is shifted |
| const_amt | input | 5 | Shift amount taken from the instruction |
| ctrl | input | 8 | Packed control word (layout in R1) |
| load_upper | input | 1 | Selects the load-upper-immediate path of the shifter |
| result | output | 32 | Selected result |
| ovf | output | 1 | Signed overflow of the add/subtract operation |
| zero | output | 1 | Adder sum is all zeros |

## Verification
The bench targets four corner cases.

- **Overflow-corrected less-than.** It compares operands of opposite sign whose difference overflows, such as the most negative value against 1. A design that takes the sign of the difference alone returns the inverted answer.
- **Overflow boundary.** It sums to exactly 0x7FFFFFFF and to one past it, with both add and subtract. A design that tests the carry-out instead of the sign rule flags unsigned wraps and misses signed ones.
- **Shift amounts.** It uses amounts 0 and 31, and variable amounts taken from an `opnd_a` whose upper bits are set. This exposes a shifter that uses the wrong stage weights or reads more than five bits.
- **Fills and load-upper.** Arithmetic right shifts of negative values show whether the fill comes from the sign. Load-upper with junk in the shift fields shows whether those fields leak into the immediate path.

// File: rtl/mfu_alu_pkg.sv
package mfu_alu_pkg;

  localparam int DATA_W = 32;
  localparam int AMT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'b00,
    CLS_SLT   = 2'b01,
    CLS_ARITH = 2'b10,
    CLS_LOGIC = 2'b11
  } alu_class_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_LEFT   = 2'b01,
    SH_RLOG   = 2'b10,
    SH_RARITH = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOR = 2'b11
  } logic_fn_e;

  // class sits in the two most significant bits, bitwise function in the two least
  typedef struct packed {
    alu_class_e  cls;
    logic        sub;
    shift_kind_e kind;
    logic        amt_var;
    logic_fn_e   lfn;
  } alu_ctrl_t;

  localparam int CTRL_W = $bits(alu_ctrl_t);

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
  import mfu_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  data_o
);

  logic [W-1:0]       data_rev;
  logic [W-1:0]       stage_in;
  logic [W-1:0]       stage_rev;
  logic [AW:0][W-1:0] stage;
  logic               fill;

  // left shift is done as a right shift of the bit-reversed word
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign data_rev[i]  = data_i[W-1-i];
    assign stage_rev[i] = stage[AW][W-1-i];
  end

  assign fill     = (kind_i == SH_RARITH) & data_i[W-1];
  assign stage_in = (kind_i == SH_LEFT) ? data_rev : data_i;
  assign stage[0] = stage_in;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{STEP{fill}}, stage[s][W-1:STEP]} : stage[s];
  end

  always_comb begin
    unique case (kind_i)
      SH_NONE:   data_o = data_i;
      SH_LEFT:   data_o = stage_rev;
      default:   data_o = stage[AW];
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);

  logic [W-1:0] b_eff;

  // subtraction: invert the second operand and feed a carry-in of one
  assign b_eff = b_i ^ {W{sub_i}};
  assign sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
  assign ovf_o = (a_i[W-1] == b_eff[W-1]) & (sum_o[W-1] != a_i[W-1]);

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import mfu_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] y_o
);

  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/mfu_alu.sv
module mfu_alu
  import mfu_alu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic [AW-1:0]     const_amt,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              load_upper,
  output logic [W-1:0]      result,
  output logic              ovf,
  output logic              zero
);

  localparam int HALF_W = W / 2;
  localparam logic [AW-1:0] LUI_AMT = AW'(HALF_W);

  alu_ctrl_t    c;
  logic         eff_sub;
  logic [W-1:0] sum;
  logic         add_ovf;
  logic [W-1:0] sh_in;
  logic [AW-1:0] sh_amt;
  shift_kind_e  sh_kind;
  logic [W-1:0] sh_out;
  logic [W-1:0] lg_out;
  logic         less;

  assign c       = alu_ctrl_t'(ctrl);
  assign eff_sub = c.sub | (c.cls == CLS_SLT);

  alu_addsub #(.W(W)) u_addsub (
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .sub_i (eff_sub),
    .sum_o (sum),
    .ovf_o (add_ovf)
  );

  assign sh_in   = load_upper ? {{(W-HALF_W){1'b0}}, opnd_b[HALF_W-1:0]} : opnd_b;
  assign sh_amt  = load_upper ? LUI_AMT : (c.amt_var ? opnd_a[AW-1:0] : const_amt);
  assign sh_kind = load_upper ? SH_LEFT : c.kind;

  alu_shifter #(.W(W), .AW(AW)) u_shift (
    .data_i (sh_in),
    .amt_i  (sh_amt),
    .kind_i (sh_kind),
    .data_o (sh_out)
  );

  alu_bitwise #(.W(W)) u_logic (
    .a_i  (opnd_a),
    .b_i  (opnd_b),
    .fn_i (c.lfn),
    .y_o  (lg_out)
  );

  // sign of the difference, corrected when the subtraction overflowed
  assign less = sum[W-1] ^ add_ovf;

  always_comb begin
    unique case (c.cls)
      CLS_SHIFT: result = sh_out;
      CLS_SLT:   result = {{(W-1){1'b0}}, less};
      CLS_ARITH: result = sum;
      default:   result = lg_out;
    endcase
  end

  assign ovf  = add_ovf & (c.cls == CLS_ARITH);
  assign zero = ~|sum;

endmodule

// File: rtl/mfu_alu_chk.sv
module mfu_alu_chk
  import mfu_alu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = $clog2(W)
) (
  input logic [W-1:0]      opnd_a,
  input logic [W-1:0]      opnd_b,
  input logic [CTRL_W-1:0] ctrl,
  input logic              load_upper,
  input logic [W-1:0]      result,
  input logic              ovf,
  input logic              zero
);

  localparam int HALF_W = W / 2;
  alu_ctrl_t c;
  assign c = alu_ctrl_t'(ctrl);

  always_comb begin
    if (c.cls == CLS_SLT)
      AST_SLT_HIGH_CLEAR: assert (result[W-1:1] == '0) else $error("slt upper bits set"); // R5
    if (c.cls == CLS_LOGIC && c.lfn == LG_AND)
      AST_AND_SUBSET: assert ((result & ~opnd_a) == '0) else $error("and result outside a"); // R6
    if (c.cls == CLS_LOGIC && c.lfn == LG_XOR)
      AST_XOR_UNDO: assert ((result ^ opnd_b) == opnd_a) else $error("xor not invertible"); // R6
    if (c.cls != CLS_ARITH)
      AST_OVF_ONLY_ARITH: assert (!ovf) else $error("ovf outside arith class"); // R3
    if (c.cls == CLS_ARITH && !c.sub && opnd_a[W-1] != opnd_b[W-1])
      AST_NO_OVERFLOW: assert (!ovf) else $error("ovf on mixed-sign add"); // R3
    if (c.cls == CLS_ARITH && zero)
      AST_ZERO_RESULT: assert (result == '0) else $error("zero with nonzero sum"); // R4
    if (c.cls == CLS_SHIFT && !load_upper && c.kind == SH_NONE)
      AST_PASS_THROUGH: assert (result == opnd_b) else $error("no-shift changed b"); // R7
    if (c.cls == CLS_SHIFT && load_upper)
      AST_LUI_LOW_CLEAR: assert (result[HALF_W-1:0] == '0 && result[W-1:HALF_W] == opnd_b[HALF_W-1:0])
        else $error("lui path wrong"); // R10
  end

endmodule

bind mfu_alu mfu_alu_chk #(.W(W), .AW(AW)) chk_i (
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .ctrl       (ctrl),
  .load_upper (load_upper),
  .result     (result),
  .ovf        (ovf),
  .zero       (zero)
);

// File: tb/mfu_alu_tb_top.sv
module mfu_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  const_amt = '0;
  logic [7:0]  ctrl = '0;
  logic        load_upper = 1'b0;
  logic [31:0] result;
  logic        ovf;
  logic        zero;

  int checks = 0;
  int errors = 0;
  int wd_cycles = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  mfu_alu dut_i (
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .const_amt  (const_amt),
    .ctrl       (ctrl),
    .load_upper (load_upper),
    .result     (result),
    .ovf        (ovf),
    .zero       (zero)
  );

  always @(posedge clk) begin
    wd_cycles <= wd_cycles + 1;
    if (wd_cycles > 100000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ctrl layout: [7:6] class, [5] sub, [4:3] kind, [2] variable amount, [1:0] bitwise fn
  function automatic logic [7:0] mk(input logic [1:0] cls, input logic sub,
                                    input logic [1:0] kind, input logic var_amt,
                                    input logic [1:0] lfn);
    return {cls, sub, kind, var_amt, lfn};
  endfunction

  task automatic cmp(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [4:0] ca,
                       input logic [7:0] cw, input logic lui);
    @(negedge clk);
    opnd_a = a; opnd_b = b; const_amt = ca; ctrl = cw; load_upper = lui;
    #2;
  endtask

  // arithmetic class with expected values from signed 64-bit math
  task automatic t_arith(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic sub);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint lr = sub ? sa - sb : sa + sb;
    logic [31:0] s = sub ? a - b : a + b;
    logic eo = (lr > 64'sd2147483647) || (lr < -64'sd2147483648);
    apply(a, b, 5'd0, mk(2'b10, sub, 2'b00, 1'b0, 2'b00), 1'b0);
    cmp(req, "sum", result, s);
    cmp("R3", "ovf", {31'b0, ovf}, {31'b0, eo});
    cmp("R4", "zero", {31'b0, zero}, {31'b0, s == 32'h0});
  endtask

  task automatic t_slt(input logic [31:0] a, input logic [31:0] b);
    apply(a, b, 5'd0, mk(2'b01, 1'b0, 2'b00, 1'b0, 2'b00), 1'b0);
    cmp("R5", "slt", result, {31'b0, $signed(a) < $signed(b)});
    cmp("R3", "ovf_slt", {31'b0, ovf}, 32'h0);
    cmp("R4", "zero_slt", {31'b0, zero}, {31'b0, a == b});
  endtask

  task automatic t_logic(input logic [31:0] a, input logic [31:0] b);
    for (int f = 0; f < 4; f++) begin
      logic [31:0] e;
      case (f)
        0: e = a & b;
        1: e = a | b;
        2: e = a ^ b;
        default: e = ~(a | b);
      endcase
      apply(a, b, 5'd0, mk(2'b11, 1'b0, 2'b00, 1'b0, 2'(f)), 1'b0);
      cmp("R6", "logic", result, e);
      cmp("R4", "zero_logic", {31'b0, zero}, {31'b0, (a + b) == 32'h0});
    end
  endtask

  task automatic t_shift(input string req, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] ca, input logic [1:0] kind, input logic var_amt);
    logic [4:0] n = var_amt ? a[4:0] : ca;
    logic [31:0] e;
    case (kind)
      2'b00: e = b;
      2'b01: e = b << n;
      2'b10: e = b >> n;
      default: e = 32'($signed(b) >>> n);
    endcase
    apply(a, b, ca, mk(2'b00, 1'b0, kind, var_amt, 2'b00), 1'b0);
    cmp(req, "shift", result, e);
  endtask

  task automatic t_lui(input logic [31:0] b, input logic [4:0] ca, input logic [1:0] kind,
                       input logic var_amt);
    apply(32'hFFFF_FFE3, b, ca, mk(2'b00, 1'b1, kind, var_amt, 2'b11), 1'b1);
    cmp("R10", "lui", result, {b[15:0], 16'h0000});
  endtask

  task automatic t_idle;
    apply('0, '0, '0, '0, 1'b0);
    cmp("R1", "idle_result", result, 32'h0);
    cmp("R4", "idle_zero", {31'b0, zero}, 32'h1);
    cmp("R3", "idle_ovf", {31'b0, ovf}, 32'h0);
  endtask

  task automatic t_class_select;
    apply(32'h0000_00F0, 32'h0000_0F0F, 5'd4, mk(2'b00, 1'b0, 2'b01, 1'b0, 2'b01), 1'b0);
    cmp("R1", "cls_shift", result, 32'h0000_F0F0);
    apply(32'h0000_00F0, 32'h0000_0F0F, 5'd4, mk(2'b10, 1'b0, 2'b01, 1'b0, 2'b01), 1'b0);
    cmp("R1", "cls_arith", result, 32'h0000_0FFF);
    apply(32'h0000_00F0, 32'h0000_0F0F, 5'd4, mk(2'b11, 1'b0, 2'b01, 1'b0, 2'b01), 1'b0);
    cmp("R1", "cls_logic", result, 32'h0000_0FFF);
    apply(32'h0000_00F0, 32'h0000_0F0F, 5'd4, mk(2'b01, 1'b0, 2'b01, 1'b0, 2'b01), 1'b0);
    cmp("R1", "cls_slt", result, 32'h0000_0001);
  endtask

  initial begin
    logic [31:0] lf = 32'hACE1_1234;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_class_select();
    // R2 add and subtract, including the signed overflow boundary of R3
    t_arith("R2", 32'h0000_0005, 32'h0000_0007, 1'b0);
    t_arith("R2", 32'h0000_0005, 32'h0000_0007, 1'b1);
    t_arith("R2", 32'h7FFF_FFFE, 32'h0000_0001, 1'b0);
    t_arith("R3", 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    t_arith("R3", 32'h8000_0000, 32'h0000_0001, 1'b1);
    t_arith("R3", 32'h8000_0000, 32'h8000_0000, 1'b0);
    t_arith("R3", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    t_arith("R4", 32'h1234_5678, 32'h1234_5678, 1'b1);
    // R5 comparisons, overflowing differences included
    t_slt(32'h8000_0000, 32'h0000_0001);
    t_slt(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    t_slt(32'hFFFF_FFFE, 32'hFFFF_FFFF);
    t_slt(32'h0000_0003, 32'h0000_0003);
    t_slt(32'h0000_0002, 32'h8000_0000);
    t_logic(32'hF0F0_A5A5, 32'hFF00_3C3C);
    t_logic(32'h0000_0001, 32'hFFFF_FFFF);
    // R7 kinds, R8 amount source, R9 fills
    t_shift("R7", 32'h0, 32'h8765_4321, 5'd9, 2'b00, 1'b0);
    t_shift("R7", 32'h0, 32'h8765_4321, 5'd0, 2'b01, 1'b0);
    t_shift("R7", 32'h0, 32'h8765_4321, 5'd31, 2'b01, 1'b0);
    t_shift("R7", 32'h0, 32'h8765_4321, 5'd12, 2'b10, 1'b0);
    t_shift("R9", 32'h0, 32'h8765_4321, 5'd31, 2'b11, 1'b0);
    t_shift("R9", 32'h0, 32'h8765_4321, 5'd7, 2'b11, 1'b0);
    t_shift("R9", 32'h0, 32'h4765_4321, 5'd7, 2'b11, 1'b0);
    t_shift("R9", 32'h0, 32'hF000_0000, 5'd4, 2'b10, 1'b0);
    t_shift("R8", 32'hFFFF_FFE5, 32'h0000_00FF, 5'd1, 2'b01, 1'b1);
    t_shift("R8", 32'h0000_0013, 32'h8000_0000, 5'd2, 2'b11, 1'b1);
    t_shift("R8", 32'h0000_0020, 32'h1234_5678, 5'd3, 2'b10, 1'b1);
    t_lui(32'hDEAD_BEEF, 5'd3, 2'b10, 1'b0);
    t_lui(32'h0000_8001, 5'd0, 2'b11, 1'b1);
    t_lui(32'hFFFF_0000, 5'd31, 2'b00, 1'b0);
    // mixed patterns from a bench-side LFSR
    for (int k = 0; k < 40; k++) begin
      logic [31:0] la;
      logic [31:0] lb;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      la = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lb = lf;
      t_arith("R2", la, lb, k[0]);
      t_slt(la, lb);
      t_shift("R7", la, lb, lb[9:5], lb[1:0], k[1]);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule